// File: doc/BRIEF.md
# Asynchronous NOR Flash Access Sequencer

This block turns single read or write requests from an internal bus into the strobe sequence that an asynchronous NOR flash expects. It works on an external bus with a 26-bit address and 16-bit data, where address and data are not multiplexed. All phase lengths are counted in system clock cycles.

Each access begins with an address setup phase. During this phase the address-valid strobe is low. A data phase follows. On a read, output enable is low for the programmed number of cycles and the data bus is captured in the final cycle. On a write, write enable is low for one cycle more than the programmed value, and the write data stays on the bus for the whole access. Reads and writes each have their own setup and data values. There is no address hold phase.

When an access ends, chip enable rises and a done pulse goes back to the requester, together with any read data. A programmable turnaround gap then keeps chip enable high for a minimum number of cycles before the next access may start. All strobes are active low and idle high.

Top module: `nor_async_seq`

## Requirements
- R1: After reset, chip enable, address valid, output enable and write enable are all high, `done` is low, `mem_dq_oe` is low and `req_ready` is high. Asserting reset in the middle of an access returns the strobes to this state.
- R2: Every access starts with address valid low for exactly A cycles while chip enable is low. A is the read or write address-setup value, and a value of 0 counts as 1.
- R3: On a read, output enable goes low for exactly D cycles right after the address phase, and write enable stays high. D is the read data-setup value, and 0 counts as 1.
- R4: On a write, write enable goes low for exactly D+1 cycles right after the address phase, and output enable stays high. D is the write data-setup value, and 0 counts as 1.
- R5: The direction bit `req_write` (1 = write) selects which timing set the access uses: `wr_aset`/`wr_dset` or `rd_aset`/`rd_dset`. Chip enable stays low for exactly the address-phase length plus the data-phase length.
- R6: A read returns the data bus value sampled in the last output-enable-low cycle on `rdata`. That value is valid while `done` is high.
- R7: `done` is high for exactly one cycle: the first cycle after chip enable rises, for both reads and writes.
- R8: Between the rise of chip enable and its next fall there are at least G high cycles. G is the gap value latched with the earlier access, and 0 counts as 1. A request held waiting is accepted so that exactly G cycles separate the two accesses. `req_ready` is low whenever chip enable is low.
- R9: The address stays stable for the whole chip-enable-low window. On a write, `mem_dq_oe` is high and `mem_dq_out` carries the write data throughout. On a read, `mem_dq_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Access address |
| req_wdata | input | 16 | Write data |
| rd_aset | input | 4 | Read address-setup cycles |
| rd_dset | input | 8 | Read data-setup cycles |
| wr_aset | input | 4 | Write address-setup cycles |
| wr_dset | input | 8 | Write data-setup cycles |
| turn_gap | input | 4 | Minimum chip-enable-high cycles between accesses |
| req_ready | output | 1 | A request is accepted in this cycle if valid |
| done | output | 1 | One-cycle access completion pulse |
| rdata | output | 16 | Read data |
| mem_addr | output | 26 | External address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
A phase counter that is off by one shows directly at the ports. The low window of address valid, output enable or write enable comes out one cycle too long or too short, and the error appears in the very access where it happens. A state register that picks the wrong direction shows the wrong enable strobe within A+1 cycles of acceptance. A gap counter that is wrong moves the next chip-enable fall early or late, and this is measured on the next back-to-back request. A capture taken on the wrong cycle returns a neighbouring bus value, because the bench's memory changes its data every output-enable cycle.

// File: rtl/nor_async_seq.sv
module nor_async_seq #(
  parameter int AW  = 26,
  parameter int DW  = 16,
  parameter int ASW = 4,
  parameter int DSW = 8,
  parameter int GW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [ASW-1:0] rd_aset,
  input  logic [DSW-1:0] rd_dset,
  input  logic [ASW-1:0] wr_aset,
  input  logic [DSW-1:0] wr_dset,
  input  logic [GW-1:0]  turn_gap,
  output logic           req_ready,
  output logic           done,
  output logic [DW-1:0]  rdata,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_ce_n,
  output logic           mem_adv_n,
  output logic           mem_oe_n,
  output logic           mem_we_n,
  output logic [DW-1:0]  mem_dq_out,
  output logic           mem_dq_oe,
  input  logic [DW-1:0]  mem_dq_in
);
  localparam int CW = DSW + 1;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;
  st_t st;

  logic [CW-1:0] cnt, dlen;
  logic [GW-1:0] gap_cnt, gap_len;
  logic          wr_q;

  wire [ASW-1:0] a_sel = req_write ? wr_aset : rd_aset;
  wire [DSW-1:0] d_sel = req_write ? wr_dset : rd_dset;
  wire [ASW-1:0] a_eff = (a_sel == '0) ? ASW'(1) : a_sel;
  wire [CW-1:0]  d_eff = ((d_sel == '0) ? CW'(1) : CW'(d_sel)) + CW'(req_write);
  wire [GW-1:0]  g_eff = (turn_gap == '0) ? GW'(1) : turn_gap;

  assign req_ready = (st == S_IDLE) && (gap_cnt == '0);
  wire   accept    = req_ready && req_valid;

  assign mem_ce_n  = (st == S_IDLE);
  assign mem_adv_n = (st != S_ADDR);
  assign mem_oe_n  = !((st == S_DATA) && !wr_q);
  assign mem_we_n  = !((st == S_DATA) && wr_q);
  assign mem_dq_oe = (st != S_IDLE) && wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      dlen       <= '0;
      gap_cnt    <= '0;
      gap_len    <= '0;
      wr_q       <= 1'b0;
      done       <= 1'b0;
      rdata      <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (gap_cnt != '0) gap_cnt <= gap_cnt - GW'(1);
          if (accept) begin
            st         <= S_ADDR;
            cnt        <= CW'(a_eff) - CW'(1);
            dlen       <= d_eff;
            gap_len    <= g_eff;
            wr_q       <= req_write;
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
          end
        end
        S_ADDR: begin
          if (cnt == '0) begin
            st  <= S_DATA;
            cnt <= dlen - CW'(1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_DATA: begin
          if (cnt == '0) begin
            st      <= S_IDLE;
            gap_cnt <= gap_len - GW'(1);
            done    <= 1'b1;
            if (!wr_q) rdata <= mem_dq_in;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_async_seq_chk.sv
module nor_async_seq_chk #(
  parameter int AW = 26
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_adv_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe
);
  assert_idle_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_adv_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_adv_in_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> !mem_ce_n);

  assert_enables_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_on_ce_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> done);

  assert_start_needs_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> $past(req_valid && req_ready));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind nor_async_seq nor_async_seq_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_nor_async_seq.sv
module test_nor_async_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [25:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  rd_aset = '0, wr_aset = '0, turn_gap = '0;
  logic [7:0]  rd_dset = '0, wr_dset = '0;
  logic        req_ready, done, mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] rdata, mem_dq_out;
  logic [15:0] mem_dq_in = '0;
  logic [25:0] mem_addr;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  nor_async_seq i_nor_async_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_aset(rd_aset), .rd_dset(rd_dset),
    .wr_aset(wr_aset), .wr_dset(wr_dset), .turn_gap(turn_gap), .req_ready(req_ready),
    .done(done), .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // {write, addr, wdata, rd_aset, rd_dset, wr_aset, wr_dset, gap}
  localparam int NV = 6;
  localparam logic [70:0] VEC [NV] = '{
    {1'b0, 26'h0001234, 16'h0000, 4'd2,  8'd3,  4'd5,  8'd7,   4'd2},
    {1'b1, 26'h3ABCDEF, 16'hBEEF, 4'd2,  8'd3,  4'd1,  8'd4,   4'd3},
    {1'b0, 26'h2000F0F, 16'h0000, 4'd0,  8'd0,  4'd9,  8'd9,   4'd0},
    {1'b1, 26'h0155AA1, 16'h1357, 4'd7,  8'd7,  4'd0,  8'd0,   4'd5},
    {1'b0, 26'h1FFFFFF, 16'h0000, 4'd15, 8'd20, 4'd1,  8'd1,   4'd15},
    {1'b1, 26'h0000000, 16'hC0DE, 4'd3,  8'd3,  4'd15, 8'd255, 4'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [15:0] mem_val(input logic [25:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  task automatic run_access(input logic [70:0] v, input int prev_gap);
    int ce_hi = 0, ce_lo = 0, adv_lo = 0, oe_lo = 0, we_lo = 0, guard = 0;
    bit started = 0, bus_ok = 1, addr_ok = 1;
    int a_exp, d_exp;
    {req_write, req_addr, req_wdata, rd_aset, rd_dset, wr_aset, wr_dset, turn_gap} = v;
    a_exp = eff(req_write ? int'(wr_aset) : int'(rd_aset));
    d_exp = eff(req_write ? int'(wr_dset) : int'(rd_dset)) + (req_write ? 1 : 0);
    req_valid = 1'b1;
    mem_dq_in = mem_val(req_addr);
    forever begin
      if (!started && mem_ce_n) ce_hi++;
      if (!mem_ce_n) begin
        started = 1;
        req_valid = 1'b0;
        ce_lo++;
        if (!mem_adv_n) adv_lo++;
        if (!mem_oe_n) oe_lo++;
        if (!mem_we_n) we_lo++;
        if (mem_addr != req_addr) addr_ok = 0;
        if (req_write ? (!mem_dq_oe || mem_dq_out != req_wdata) : mem_dq_oe) bus_ok = 0;
        mem_dq_in = mem_val(req_addr) + 16'(oe_lo);
      end
      if (started && done) break;
      guard++;
      if (guard > 2000) begin
        chk(0, "R7 access never completed", guard, 0);
        return;
      end
      @(negedge clk);
    end
    chk(adv_lo == a_exp, "R2 address-valid low cycles", adv_lo, a_exp);
    if (req_write) begin
      chk(we_lo == d_exp, "R4 write-enable low cycles", we_lo, d_exp);
      chk(oe_lo == 0, "R4 output enable during write", oe_lo, 0);
    end else begin
      chk(oe_lo == d_exp, "R3 output-enable low cycles", oe_lo, d_exp);
      chk(we_lo == 0, "R3 write enable during read", we_lo, 0);
      chk(rdata == mem_val(req_addr) + 16'(d_exp), "R6 read data from last cycle",
          rdata, mem_val(req_addr) + 16'(d_exp));
    end
    chk(ce_lo == a_exp + d_exp, "R5 chip-enable low cycles", ce_lo, a_exp + d_exp);
    chk(mem_ce_n && done, "R7 done with chip enable high", done, 1);
    chk(addr_ok, "R9 address held", addr_ok, 1);
    chk(bus_ok, "R9 data bus drive", bus_ok, 1);
    if (prev_gap >= 0)
      chk(ce_hi == eff(prev_gap), "R8 turnaround gap", ce_hi, eff(prev_gap));
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_adv_n && mem_oe_n && mem_we_n, "R1 strobes in reset", 0, 1);
    chk(!done && !mem_dq_oe, "R1 done/drive in reset", {done, mem_dq_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_ce_n, "R1 ready after reset", req_ready, 1);
    @(negedge clk);
    chk(!done, "R7 no done without access", done, 0);

    for (int i = 0; i < NV; i++)
      run_access(VEC[i], (i == 0) ? -1 : int'(VEC[i-1][3:0]));

    // R7 done lasts one cycle
    @(negedge clk);
    chk(!done, "R7 done single cycle", done, 0);

    // R1 reset mid-access
    repeat (20) @(negedge clk);
    req_write = 1'b1; wr_aset = 4'd3; wr_dset = 8'd10; req_valid = 1'b1;
    repeat (6) @(negedge clk);
    req_valid = 1'b0;
    chk(!mem_we_n, "R4 write in progress before reset", mem_we_n, 0);
    rst_n = 1'b0;
    #1;
    chk(mem_ce_n && mem_we_n && mem_adv_n && mem_oe_n && !mem_dq_oe,
        "R1 strobes after mid-access reset", mem_ce_n, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after mid-access reset", req_ready, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule